// File: doc/BRIEF.md
# Floating-Point Set-on-Comparison Unit

This block compares two floating-point operands and records whether a chosen relation holds in a one-bit status flag. Each request picks one of six relations and a precision. Single precision uses 32-bit operands. Double precision uses 64-bit operands, each built from an even/odd pair of 32-bit register words.

The register file sits outside the block. For a double operand it reads the pair at an even register number and presents the even word and the odd word on separate ports. The even word carries the sign, the exponent and the high mantissa bits. The odd word carries the low mantissa bits.

Ordering follows IEEE-754. The two signed zeros compare equal. A NaN on either side makes the pair unordered. One clock after each request the flag updates and a completion pulse is raised.

Top module: `fpcmp_flag_unit`

## Requirements
- R1: `cond_sel` selects the relation: 0 = a<b, 1 = a>b, 2 = a==b, 3 = a<=b, 4 = a>=b, 5 = a!=b. The flag becomes 1 when the selected relation holds and 0 when it does not.
- R2: The flag and `done_q` update on the first clock edge after a cycle with `req_valid` high, and `done_q` is high for exactly that one cycle. In a cycle without a request the flag keeps its value and `done_q` is low.
- R3: `cond_sel` codes 6 and 7 leave the flag unchanged, and `done_q` still pulses.
- R4: With `dbl_mode`=0 each operand is its even word alone, and the odd words have no effect.
- R5: Positive zero and negative zero compare as equal in both precisions.
- R6: If either operand is a NaN (exponent all ones, mantissa non-zero), codes 0 to 4 give 0 and code 5 gives 1.
- R7: Operands are ordered by value. A more negative value is smaller, and the infinities sit at the two ends.
- R8: After reset `flag_q` and `done_q` are both 0.
- R9: Precision is chosen per request. With `dbl_mode`=1 each operand is {even word, odd word}, with the even word in bits 63:32, and a difference confined to the odd word decides the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | One comparison request this cycle |
| cond_sel | input | 3 | Relation code |
| dbl_mode | input | 1 | 1 = double precision, 0 = single |
| a_even_word | input | 32 | Operand A, even register word |
| a_odd_word | input | 32 | Operand A, odd register word (double only) |
| b_even_word | input | 32 | Operand B, even register word |
| b_odd_word | input | 32 | Operand B, odd register word (double only) |
| flag_q | output | 1 | Status flag holding the last result |
| done_q | output | 1 | One-cycle completion pulse |

## Verification
Some properties are checked on every cycle:
- the one-cycle timing of the completion pulse;
- that the flag holds when idle or on a reserved code;
- that an unordered pair drives the flag to 0 for codes 0 to 4 and to 1 for not-equal;
- that less-than, equal and unordered are mutually exclusive.

Other behaviours need known operand values, so only the directed scenarios show them:
- signed-zero equality;
- negative and infinite ordering;
- that odd words are ignored in single precision;
- that an odd-word difference decides a double comparison.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;
   localparam int unsigned COND_W = 3;
   localparam logic [COND_W-1:0] COND_LT = 3'd0;
   localparam logic [COND_W-1:0] COND_GT = 3'd1;
   localparam logic [COND_W-1:0] COND_EQ = 3'd2;
   localparam logic [COND_W-1:0] COND_LE = 3'd3;
   localparam logic [COND_W-1:0] COND_GE = 3'd4;
   localparam logic [COND_W-1:0] COND_NE = 3'd5;

   typedef struct packed {
      logic lt;
      logic eq;
      logic unord;
   } cmp_rel_t;
endpackage

// File: rtl/fpcmp_order.sv
module fpcmp_order #(
   parameter int unsigned EXP_W = 8,
   parameter int unsigned MAN_W = 23,
   localparam int unsigned W = 1 + EXP_W + MAN_W
) (
   input  logic [W-1:0]         op_a,
   input  logic [W-1:0]         op_b,
   output fpcmp_pkg::cmp_rel_t  rel
);
   initial begin
      assert (EXP_W >= 2 && MAN_W >= 1)
         else $error("fpcmp_order: exponent or mantissa too narrow");
   end

   logic          sign_a, sign_b;
   logic [W-2:0]  mag_a, mag_b;
   logic          nan_a, nan_b, unord, both_zero, lt_raw;

   assign sign_a    = op_a[W-1];
   assign sign_b    = op_b[W-1];
   assign mag_a     = op_a[W-2:0];
   assign mag_b     = op_b[W-2:0];
   assign nan_a     = (&op_a[W-2:MAN_W]) && (|op_a[MAN_W-1:0]);
   assign nan_b     = (&op_b[W-2:MAN_W]) && (|op_b[MAN_W-1:0]);
   assign unord     = nan_a || nan_b;
   assign both_zero = (mag_a == '0) && (mag_b == '0);

   always_comb begin
      unique case ({sign_a, sign_b})
         2'b00:   lt_raw = mag_a < mag_b;
         2'b11:   lt_raw = mag_a > mag_b;
         2'b10:   lt_raw = !both_zero;
         default: lt_raw = 1'b0;
      endcase
   end

   assign rel.unord = unord;
   assign rel.eq    = !unord && ((op_a == op_b) || both_zero);
   assign rel.lt    = !unord && lt_raw;
endmodule

// File: rtl/fpcmp_cond_select.sv
module fpcmp_cond_select
   import fpcmp_pkg::*;
(
   input  cmp_rel_t            rel,
   input  logic [COND_W-1:0]   cond,
   output logic                code_ok,
   output logic                result
);
   logic gt;
   assign gt = !rel.lt && !rel.eq && !rel.unord;

   always_comb begin
      code_ok = 1'b1;
      unique case (cond)
         COND_LT: result = rel.lt;
         COND_GT: result = gt;
         COND_EQ: result = rel.eq;
         COND_LE: result = rel.lt || rel.eq;
         COND_GE: result = gt || rel.eq;
         COND_NE: result = !rel.eq;
         default: begin
            result  = 1'b0;
            code_ok = 1'b0;
         end
      endcase
   end
endmodule

// File: rtl/fpcmp_flag_unit.sv
module fpcmp_flag_unit
   import fpcmp_pkg::*;
#(
   parameter int unsigned WORD_W   = 32,
   parameter int unsigned SP_EXP_W = 8,
   parameter int unsigned SP_MAN_W = 23,
   parameter int unsigned DP_EXP_W = 11,
   parameter int unsigned DP_MAN_W = 52
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   input  logic [2:0]          cond_sel,
   input  logic                dbl_mode,
   input  logic [WORD_W-1:0]   a_even_word,
   input  logic [WORD_W-1:0]   a_odd_word,
   input  logic [WORD_W-1:0]   b_even_word,
   input  logic [WORD_W-1:0]   b_odd_word,
   output logic                flag_q,
   output logic                done_q
);
   localparam int unsigned SP_W = 1 + SP_EXP_W + SP_MAN_W;
   localparam int unsigned DP_W = 1 + DP_EXP_W + DP_MAN_W;
   localparam int unsigned N_OP = 2;

   initial begin
      assert (SP_W == WORD_W) else $error("single format must fill one word");
      assert (DP_W == 2 * WORD_W) else $error("double format must fill two words");
      assert (COND_W == 3) else $error("condition code width mismatch");
   end

   logic [WORD_W-1:0] even_w [N_OP];
   logic [WORD_W-1:0] odd_w  [N_OP];
   logic [SP_W-1:0]   sp_op  [N_OP];
   logic [DP_W-1:0]   dp_op  [N_OP];

   assign even_w[0] = a_even_word;
   assign even_w[1] = b_even_word;
   assign odd_w[0]  = a_odd_word;
   assign odd_w[1]  = b_odd_word;

   // Even register carries the upper half of a double operand.
   for (genvar i = 0; i < N_OP; i++) begin : g_join
      assign sp_op[i] = even_w[i];
      assign dp_op[i] = {even_w[i], odd_w[i]};
   end

   cmp_rel_t sp_rel, dp_rel, sel_rel;

   fpcmp_order #(.EXP_W(SP_EXP_W), .MAN_W(SP_MAN_W)) u_sp_order (
      .op_a (sp_op[0]),
      .op_b (sp_op[1]),
      .rel  (sp_rel)
   );

   fpcmp_order #(.EXP_W(DP_EXP_W), .MAN_W(DP_MAN_W)) u_dp_order (
      .op_a (dp_op[0]),
      .op_b (dp_op[1]),
      .rel  (dp_rel)
   );

   assign sel_rel = dbl_mode ? dp_rel : sp_rel;

   logic code_ok, result;

   fpcmp_cond_select u_select (
      .rel     (sel_rel),
      .cond    (cond_sel),
      .code_ok (code_ok),
      .result  (result)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= req_valid;
         if (req_valid && code_ok) flag_q <= result;
      end
   end

   AST_DONE_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> done_q); // R2
   AST_DONE_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !done_q); // R2
   AST_FLAG_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> $stable(flag_q)); // R2
   AST_RESERVED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && cond_sel >= 3'd6) |=> $stable(flag_q)); // R3
   AST_UNORD_NE_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && sel_rel.unord && cond_sel == COND_NE) |=> flag_q); // R6
   AST_UNORD_OTHERS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && sel_rel.unord && cond_sel < COND_NE) |=> !flag_q); // R6
   AST_REL_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({sel_rel.lt, sel_rel.eq, sel_rel.unord})); // R7
endmodule

// File: tb/fpcmp_flag_unit_bench.sv
module fpcmp_flag_unit_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [2:0]  cond_sel = 3'd0;
   logic        dbl_mode = 1'b0;
   logic [31:0] a_even_word = '0, a_odd_word = '0;
   logic [31:0] b_even_word = '0, b_odd_word = '0;
   logic        flag_q, done_q;

   int checks = 0;
   int fails  = 0;

   always #10 clk = ~clk; // 50 MHz

   fpcmp_flag_unit u_fpcmp_flag_unit (
      .clk, .rst_n, .req_valid, .cond_sel, .dbl_mode,
      .a_even_word, .a_odd_word, .b_even_word, .b_odd_word,
      .flag_q, .done_q
   );

   task automatic chk(input string req, input logic got, input logic exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %0b expected %0b", req, got, exp);
      end
   endtask

   // One request; sample flag and done one cycle later.
   task automatic issue(input logic [2:0] c, input logic d,
                        input logic [31:0] ae, input logic [31:0] ao,
                        input logic [31:0] be, input logic [31:0] bo,
                        output logic f, output logic dn);
      @(negedge clk);
      req_valid = 1'b1; cond_sel = c; dbl_mode = d;
      a_even_word = ae; a_odd_word = ao; b_even_word = be; b_odd_word = bo;
      @(negedge clk);
      f = flag_q; dn = done_q;
      req_valid = 1'b0;
   endtask

   // Runs all six codes against expected lt / eq / unordered (R1).
   task automatic sweep(input string req, input logic d,
                        input logic [31:0] ae, input logic [31:0] ao,
                        input logic [31:0] be, input logic [31:0] bo,
                        input logic lt, input logic eq, input logic un);
      logic gt, f, dn;
      logic exp_v [6];
      gt = !lt && !eq && !un;
      exp_v[0] = lt; exp_v[1] = gt; exp_v[2] = eq;
      exp_v[3] = lt || eq; exp_v[4] = gt || eq; exp_v[5] = !eq;
      for (int c = 0; c < 6; c++) begin
         issue(3'(c), d, ae, ao, be, bo, f, dn);
         chk($sformatf("%s/R1 code%0d", req, c), f, exp_v[c]);
         chk($sformatf("%s/R2 done code%0d", req, c), dn, 1'b1);
      end
   endtask

   task automatic test_reset();
      chk("R8 flag after reset", flag_q, 1'b0);
      chk("R8 done after reset", done_q, 1'b0);
   endtask

   task automatic test_single_order();
      sweep("R1 sp 1<2", 0, 32'h3F80_0000, 0, 32'h4000_0000, 0, 1, 0, 0);
      sweep("R7 sp -1>-2", 0, 32'hBF80_0000, 0, 32'hC000_0000, 0, 0, 0, 0);
      sweep("R7 sp -inf<+inf", 0, 32'hFF80_0000, 0, 32'h7F80_0000, 0, 1, 0, 0);
      sweep("R7 sp -1<+0", 0, 32'hBF80_0000, 0, 32'h0000_0000, 0, 1, 0, 0);
   endtask

   task automatic test_zeros();
      sweep("R5 sp +0 -0", 0, 32'h0000_0000, 0, 32'h8000_0000, 0, 0, 1, 0);
      sweep("R5 dp -0 +0", 1, 32'h8000_0000, 0, 32'h0000_0000, 0, 0, 1, 0);
   endtask

   task automatic test_nan();
      sweep("R6 sp nan vs 1", 0, 32'h7FC0_0000, 0, 32'h3F80_0000, 0, 0, 0, 1);
      sweep("R6 sp nan vs nan", 0, 32'hFFC0_0001, 0, 32'hFFC0_0001, 0, 0, 0, 1);
      sweep("R6 dp nan low-only", 1, 32'h7FF0_0000, 32'h0000_0001,
            32'h0000_0000, 0, 0, 0, 1);
   endtask

   task automatic test_single_ignores_odd();
      sweep("R4 sp odd ignored", 0, 32'h3F80_0000, 32'hDEAD_BEEF,
            32'h3F80_0000, 32'h0000_0001, 0, 1, 0);
      sweep("R4 sp lo differ eq", 0, 32'h3FF0_0000, 32'h0000_0001,
            32'h3FF0_0000, 32'h0000_0000, 0, 1, 0);
   endtask

   task automatic test_double_pairs();
      sweep("R9 dp lo decides", 1, 32'h3FF0_0000, 32'h0000_0001,
            32'h3FF0_0000, 32'h0000_0000, 0, 0, 0);
      sweep("R9 dp hi decides", 1, 32'hC000_0000, 32'hFFFF_FFFF,
            32'hBFF0_0000, 32'h0000_0000, 1, 0, 0);
      sweep("R9 dp equal", 1, 32'h4009_21FB, 32'h5444_2D18,
            32'h4009_21FB, 32'h5444_2D18, 0, 1, 0);
   endtask

   task automatic test_reserved();
      logic f, dn;
      issue(3'd2, 0, 32'h3F80_0000, 0, 32'h3F80_0000, 0, f, dn);
      chk("R1 eq sets flag", f, 1'b1);
      issue(3'd6, 0, 32'h3F80_0000, 0, 32'h4000_0000, 0, f, dn);
      chk("R3 code6 keeps 1", f, 1'b1);
      chk("R3 code6 done", dn, 1'b1);
      issue(3'd2, 0, 32'h3F80_0000, 0, 32'h4000_0000, 0, f, dn);
      chk("R1 eq clears flag", f, 1'b0);
      issue(3'd7, 0, 32'h3F80_0000, 0, 32'h3F80_0000, 0, f, dn);
      chk("R3 code7 keeps 0", f, 1'b0);
      chk("R3 code7 done", dn, 1'b1);
   endtask

   task automatic test_idle();
      logic f, dn;
      issue(3'd5, 0, 32'h3F80_0000, 0, 32'h4000_0000, 0, f, dn);
      chk("R1 ne sets flag", f, 1'b1);
      a_even_word = 32'h3F80_0000; b_even_word = 32'h3F80_0000;
      cond_sel = 3'd5;
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         chk("R2 idle flag holds", flag_q, 1'b1);
         chk("R2 idle done low", done_q, 1'b0);
      end
   endtask

   initial begin
      #1;
      test_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      test_reset();
      test_single_order();
      test_zeros();
      test_nan();
      test_single_ignores_odd();
      test_double_pairs();
      test_reserved();
      test_idle();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule